// File: doc/BRIEF.md
# One-Shot Interrupt Countdown Timer

This block is a 16-bit down-counter that raises an interrupt to a CPU after a programmed number of CPU cycles. Software first loads a 16-bit reload value, one byte per register write, then writes a control register. The control write drops any pending interrupt, loads the reload value into the counter, and arms or disarms the count depending on bit 0 of the written data.

While armed, the counter loses one on every cycle in which the per-cycle `tick` strobe is high. The interrupt fires on the step that takes the counter from 0x0000 to 0xFFFF, not on the step that reaches zero, so a reload value of N fires after N+1 counted ticks. Firing also disarms the counter. The interrupt output then stays high until software rearms the timer or reset is applied.

Top module: `cd_irq_timer`

## Requirements
- R1: A register write takes effect only when `wr_en` is high and `wr_addr` is at or above 0x6000. Bits [3:0] of `wr_addr` select the register, and the upper address bits are otherwise ignored (0x600B and 0xFFFB reach the same register).
- R2: Register index 0xB writes bits [7:0] of the reload value, and index 0xC writes bits [15:8]. Each of these writes leaves the other byte unchanged.
- R3: A write to index 0xA drives `irq` low from the next cycle. It also copies the reload value into the counter and arms the counter exactly when `wr_data[0]` is 1.
- R4: While armed, the counter decrements by one on each cycle with `tick` high and holds on cycles with `tick` low. While disarmed, `tick` has no effect.
- R5: The decrement from 0x0000 to 0xFFFF raises `irq` and disarms the counter on the same clock edge. With reload value N, `irq` is first seen high after the edge that consumes the (N+1)-th armed tick, for every N from 0 to 0xFFFF.
- R6: Once high, `irq` stays high through any number of further ticks and writes to other indices. Only an index-0xA write or reset clears it.
- R7: Reset clears `irq`, the arm state, the counter and the reload value to zero.
- R8: If an index-0xA write and a `tick` fall in the same cycle, the write wins: the counter loads the reload value and that tick is not counted.
- R9: Writes to register indices other than 0xA, 0xB and 0xC do not change the reload value, the counter, the arm state or `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| tick | input | 1 | Count strobe, high once per counted CPU cycle |
| irq | output | 1 | Interrupt request, held high until cleared |

## Verification
The hardest case to reach is the control write that arrives while the timer is mid-countdown and a tick is present in the very same cycle, because the write must override the decrement. The stimulus arms the timer, spends a few ticks, then issues the control write with `tick` still high. It then counts the ticks to the interrupt from the reload. A full 0xFFFF reload is also run to the end to reach the largest wrap, and a reset is applied mid-count to show that the arm state is dropped.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    localparam int unsigned CDT_ADDR_W   = 16;
    localparam int unsigned CDT_DATA_W   = 8;
    localparam int unsigned CDT_BYTES    = 2;
    localparam int unsigned CDT_IDX_W    = 4;
    localparam logic [CDT_ADDR_W-1:0] CDT_BASE = 16'h6000;

    typedef enum logic [CDT_IDX_W-1:0] {
        IDX_CTRL    = 4'hA,
        IDX_RELOAD0 = 4'hB
    } cdt_idx_e;
endpackage

// File: rtl/cdt_wr_decode.sv
module cdt_wr_decode #(
    parameter int unsigned ADDR_W = cdt_pkg::CDT_ADDR_W,
    parameter int unsigned IDX_W  = cdt_pkg::CDT_IDX_W,
    parameter int unsigned BYTES  = cdt_pkg::CDT_BYTES,
    parameter logic [ADDR_W-1:0] BASE = cdt_pkg::CDT_BASE
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              ctrl_stb,
    output logic [BYTES-1:0]  reload_stb
);
    logic             hit;
    logic [IDX_W-1:0] idx;

    always_comb begin
        hit      = wr_en && (wr_addr >= BASE);
        idx      = wr_addr[IDX_W-1:0];
        ctrl_stb = hit && (idx == cdt_pkg::IDX_CTRL);
    end

    // One strobe per reload byte, on consecutive indices from the first one
    for (genvar b = 0; b < BYTES; b++) begin : g_byte_stb
        localparam logic [IDX_W-1:0] BYTE_IDX = IDX_W'(int'(cdt_pkg::IDX_RELOAD0) + b);
        assign reload_stb[b] = hit && (idx == BYTE_IDX);
    end
endmodule

// File: rtl/cdt_reload_reg.sv
module cdt_reload_reg #(
    parameter int unsigned DATA_W = cdt_pkg::CDT_DATA_W,
    parameter int unsigned BYTES  = cdt_pkg::CDT_BYTES,
    localparam int unsigned VAL_W = DATA_W * BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTES-1:0]  byte_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic [VAL_W-1:0]  reload
);
    logic [VAL_W-1:0] reload_d, reload_q;

    always_comb begin
        reload_d = reload_q;
        for (int b = 0; b < int'(BYTES); b++) begin
            if (byte_stb[b]) begin
                reload_d[b*DATA_W +: DATA_W] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else begin
            reload_q <= reload_d;
        end
    end

    assign reload = reload_q;
endmodule

// File: rtl/cdt_down_counter.sv
module cdt_down_counter #(
    parameter int unsigned CNT_W = cdt_pkg::CDT_DATA_W * cdt_pkg::CDT_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             arm,
    input  logic [CNT_W-1:0] reload,
    input  logic             tick,
    output logic             armed,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    typedef struct packed {
        logic             en;
        logic             irq;
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic       wrap;

    always_comb begin
        s_d  = s_q;
        wrap = (s_q.cnt == '0);
        if (load) begin
            s_d.irq = 1'b0;
            s_d.en  = arm;
            s_d.cnt = reload;
        end else if (s_q.en && tick) begin
            s_d.cnt = s_q.cnt - 1'b1;
            if (wrap) begin
                s_d.irq = 1'b1;
                s_d.en  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign armed = s_q.en;
    assign count = s_q.cnt;
    assign irq   = s_q.irq;
endmodule

// File: rtl/cd_irq_timer.sv
module cd_irq_timer #(
    parameter int unsigned ADDR_W = cdt_pkg::CDT_ADDR_W,
    parameter int unsigned DATA_W = cdt_pkg::CDT_DATA_W,
    parameter int unsigned BYTES  = cdt_pkg::CDT_BYTES,
    localparam int unsigned CNT_W = DATA_W * BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick,
    output logic              irq
);
    logic             ctrl_stb;
    logic [BYTES-1:0] reload_stb;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] cnt_val;
    logic             armed;

    cdt_wr_decode #(
        .ADDR_W (ADDR_W),
        .IDX_W  (cdt_pkg::CDT_IDX_W),
        .BYTES  (BYTES),
        .BASE   (ADDR_W'(cdt_pkg::CDT_BASE))
    ) u_dec (
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .ctrl_stb   (ctrl_stb),
        .reload_stb (reload_stb)
    );

    cdt_reload_reg #(
        .DATA_W (DATA_W),
        .BYTES  (BYTES)
    ) u_reload (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_stb (reload_stb),
        .wr_data  (wr_data),
        .reload   (reload_val)
    );

    cdt_down_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (ctrl_stb),
        .arm    (wr_data[0]),
        .reload (reload_val),
        .tick   (tick),
        .armed  (armed),
        .count  (cnt_val),
        .irq    (irq)
    );
endmodule

// File: rtl/cd_irq_timer_chk.sv
module cd_irq_timer_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              tick,
    input logic              irq,
    input logic              armed,
    input logic [CNT_W-1:0]  cnt_val,
    input logic [CNT_W-1:0]  reload_val
);
    logic in_map, ctrl_w, other_w;
    assign in_map  = wr_en && (wr_addr >= ADDR_W'(16'h6000));
    assign ctrl_w  = in_map && (wr_addr[3:0] == 4'hA);
    assign other_w = in_map && (wr_addr[3:0] != 4'hA) &&
                     (wr_addr[3:0] != 4'hB) && (wr_addr[3:0] != 4'hC);

    p_low_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr < ADDR_W'(16'h6000))) |=> $stable(reload_val));

    p_ctrl_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_w |=> !irq);

    p_ctrl_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_w |=> (cnt_val == $past(reload_val)) && (armed == $past(wr_data[0])));

    p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && tick && !ctrl_w) |=> (cnt_val == CNT_W'($past(cnt_val) - 1'b1)));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(armed && tick) && !ctrl_w) |=> $stable(cnt_val));

    p_fire_disarms_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (!armed && (cnt_val == '1)));

    p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ctrl_w) |=> irq);

    p_other_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (other_w && !(armed && tick)) |=> ($stable(cnt_val) && $stable(armed) &&
                                           $stable(irq) && $stable(reload_val)));
endmodule

bind cd_irq_timer cd_irq_timer_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .tick       (tick),
    .irq        (irq),
    .armed      (armed),
    .cnt_val    (cnt_val),
    .reload_val (reload_val)
);

// File: tb/cd_irq_timer_bench.sv
`timescale 1ns/1ps
module cd_irq_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        tick = 1'b0;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Behavioural reference state
    int m_lat = 0;
    int m_cnt = 0;
    bit m_en  = 0;
    bit m_irq = 0;

    always #5 clk = ~clk;

    cd_irq_timer u_cd_irq_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tick    (tick),
        .irq     (irq)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_lat = 0; m_cnt = 0; m_en = 0; m_irq = 0;
        end else begin
            bit hit;
            int idx;
            hit = wr_en && (int'(wr_addr) >= 'h6000);
            idx = int'(wr_addr) % 16;
            if (hit && idx == 10) begin
                m_irq = 0;
                m_en  = wr_data[0];
                m_cnt = m_lat;
            end else if (m_en && tick) begin
                m_cnt = (m_cnt + 65535) % 65536;
                if (m_cnt == 65535) begin
                    m_irq = 1;
                    m_en  = 0;
                end
            end
            if (hit && idx == 11) m_lat = (m_lat / 256) * 256 + int'(wr_data);
            if (hit && idx == 12) m_lat = (m_lat % 256) + 256 * int'(wr_data);
        end
    end

    // Per-cycle comparison against the reference (R5 and all others)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (irq !== m_irq) begin
                failures++;
                $display("FAIL R5 model compare at %0t: irq=%0b expected=%0b", $time, irq, m_irq);
            end
        end
    end

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic tk = 1'b0);
        wr_en = 1'b1; wr_addr = a; wr_data = d; tick = tk;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic set_reload(input int v);
        wr(16'h600B, 8'(v % 256));
        wr(16'h600C, 8'(v / 256));
    endtask

    // Ticks every cycle until irq; returns ticks consumed
    task automatic run_to_irq(input int limit, output int n);
        n = 0;
        tick = 1'b1;
        while (n < limit) begin
            @(negedge clk);
            n++;
            if (irq) break;
        end
        tick = 1'b0;
    endtask

    task automatic idle_ticks(input int k);
        tick = 1'b1;
        repeat (k) @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 irq low after reset", irq, 0);

        // R7: reload value cleared by reset -> one tick to fire
        wr(16'h600A, 8'h01);
        run_to_irq(10, n);
        check("R7 reset reload=0 ticks", n, 1);

        // R2/R5: reload 5 -> 6 ticks
        set_reload(5);
        wr(16'h600A, 8'h01);
        check("R3 irq cleared by ctrl write", irq, 0);
        run_to_irq(20, n);
        check("R5 reload 5 ticks", n, 6);

        // R6: irq holds through more ticks and other-index writes
        idle_ticks(10);
        wr(16'h6009, 8'hFF);
        wr(16'h600D, 8'h01);
        check("R6 irq held", irq, 1);

        // R3: disarm write clears irq and ticks then do nothing (R4)
        wr(16'h600A, 8'h00);
        check("R3 disarm clears irq", irq, 0);
        idle_ticks(20);
        check("R4 disarmed ticks ignored", irq, 0);

        // R2: byte writes keep other byte
        set_reload(3);
        wr(16'h600C, 8'h01);
        wr(16'h600A, 8'h01);
        run_to_irq(400, n);
        check("R2 high byte keeps low byte (0x0103)", n, 260);

        // R1: low address and wr_en=0 ignored
        wr(16'h500B, 8'h77);
        wr_addr = 16'h600C; wr_data = 8'h20; tick = 1'b0;
        @(negedge clk);
        wr(16'h600A, 8'h01);
        run_to_irq(400, n);
        check("R1 ignored writes, reload stays 0x0103", n, 260);

        // R1: upper address bits ignored above base
        wr(16'hFFFB, 8'h02);
        wr(16'h7FFC, 8'h00);
        wr(16'hA00A, 8'h01);
        run_to_irq(20, n);
        check("R1 aliased indices reload 2", n, 3);

        // R4: gaps in tick do not count
        set_reload(3);
        wr(16'h600A, 8'h01);
        n = 0;
        for (int i = 0; i < 20 && !irq; i++) begin
            tick = (i % 3 == 0);
            @(negedge clk);
            if (i % 3 == 0) n++;
        end
        tick = 1'b0;
        check("R4 sparse ticks to irq", n, 4);

        // R9: other indices mid-count have no effect
        set_reload(10);
        wr(16'h600A, 8'h01);
        idle_ticks(3);
        wr(16'h600D, 8'h55);
        wr(16'h6005, 8'h00);
        wr(16'h600F, 8'h01);
        run_to_irq(30, n);
        check("R9 other index writes ignored", n, 8);

        // R8: ctrl write with simultaneous tick reloads
        set_reload(4);
        wr(16'h600A, 8'h01);
        idle_ticks(2);
        wr(16'h600A, 8'h01, 1'b1);
        run_to_irq(20, n);
        check("R8 ctrl beats tick", n, 5);

        // R7: reset mid-count drops arm state
        set_reload(50);
        wr(16'h600A, 8'h01);
        idle_ticks(5);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        idle_ticks(100);
        check("R7 reset mid count disarms", irq, 0);
        wr(16'h600A, 8'h01);
        run_to_irq(10, n);
        check("R7 reload cleared mid count", n, 1);

        // R5: largest reload wraps after 65536 ticks
        set_reload(65535);
        wr(16'h600A, 8'h01);
        run_to_irq(70000, n);
        check("R5 reload 0xFFFF ticks", n, 65536);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule